// File: doc/BRIEF.md
# Event-Code Timestamp Table

The block records, for every value of an 8-bit event code, the time at which that code was last seen. Each entry has a seconds word, a nanoseconds word and a status. The low 17 bits of the nanoseconds word carry a pulse ID. The status is reported as 0 when the entry is good and as all ones when it is not. Whenever a non-zero code arrives with its interrupt enable set, the current timestamp and status are copied into that code's entry. Entry 0 has its own path: it is refreshed by a separate periodic strobe, nominally at 120 Hz, and never by receiving code 0.

A simple address/data port programs the per-code enables. A registered read port returns the entry for a requested code one cycle later. If the entry is not valid, the read returns the fallback system time instead, with the pulse ID field forced to the invalid value. Event decoding and trigger generation happen elsewhere.

Top module: `evt_stamp_table`

## Requirements
- R1: After reset every entry reads back as invalid, giving the fallback result described in R8, and `rd_valid` is 0 until a read is requested.
- R2: When `evt_vld` is 1, `evt_code` is not 0 and that code's enable is 1, the entry for that code captures `cur_sec`, `cur_nsec` and `cur_ok` at the clock edge.
- R3: An event whose code enable is 0 leaves that code's entry unchanged. This includes an entry that was written earlier.
- R4: An event with code 0 never writes. Entry 0 is written from the current timestamp on every cycle where `tick120` is 1, whatever its enable bit holds.
- R5: When `en_we` is 1, enable bit `en_addr` takes the value `en_data` at the clock edge. An event in that same cycle sees the old enable value. All enables reset to 0.
- R6: A read requested with `rd_en` in one cycle presents its result, with `rd_valid` = 1, after the next rising edge. In a cycle without a request, `rd_valid` is 0 and the data outputs hold their previous values.
- R7: A read of a valid entry returns the stored seconds and nanoseconds words and `rd_status` = 0x00000000.
- R8: A read of an invalid entry returns `sys_sec`, and `sys_nsec` with bits 16:0 forced to 0x1FFFF, both sampled in the request cycle, and `rd_status` = 0xFFFFFFFF. This covers entries never written and entries written with `cur_ok` = 0.
- R9: A read of a code that is written in the same cycle returns the newly written value. This holds both for an event write and for the `tick120` write of entry 0.
- R10: A `tick120` update of entry 0 and an event write of a non-zero code in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_sec | input | 32 | Current seconds word |
| cur_nsec | input | 32 | Current nanoseconds word, pulse ID in bits 16:0 |
| cur_ok | input | 1 | Current timestamp is valid |
| sys_sec | input | 32 | Fallback system seconds |
| sys_nsec | input | 32 | Fallback system nanoseconds |
| evt_vld | input | 1 | An event code is present this cycle |
| evt_code | input | 8 | Received event code |
| tick120 | input | 1 | Periodic update strobe for entry 0 |
| en_we | input | 1 | Enable register write strobe |
| en_addr | input | 8 | Code whose enable is written |
| en_data | input | 1 | New enable value |
| rd_en | input | 1 | Read request |
| rd_code | input | 8 | Code to read |
| rd_valid | output | 1 | Read result present |
| rd_sec | output | 32 | Read seconds word |
| rd_nsec | output | 32 | Read nanoseconds word |
| rd_status | output | 32 | 0 for good, all ones for invalid |

## Verification
Writes to the table and to the enable bits take effect at the edge that samples them, so their effect can only be seen through a read issued in a later cycle. A read result is due exactly one edge after the request. The bench drives every stimulus on a falling edge, lets one rising edge pass, and compares the outputs at the following falling edge, which is one edge after the request. For a read issued in the same cycle as a write, the expected value is taken from the bench's model after that write has been applied.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int unsigned SEC_W  = 32;
  localparam int unsigned NSEC_W = 32;

  typedef struct packed {
    logic              ok;
    logic [NSEC_W-1:0] nsec;
    logic [SEC_W-1:0]  sec;
  } stamp_t;
endpackage

// File: rtl/evt_irq_enables.sv
module evt_irq_enables #(
  parameter int unsigned CODE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CODE_W-1:0]      addr,
  input  logic                   data,
  output logic [(1<<CODE_W)-1:0] en_q
);
  localparam int unsigned N = 1 << CODE_W;

  logic [N-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (we) en_d[addr] = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assert_en_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> en_q[$past(addr)] == $past(data));
endmodule

// File: rtl/evt_stamp_store.sv
module evt_stamp_store
  import evt_stamp_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_we,
  input  logic [CODE_W-1:0] evt_addr,
  input  logic              tick_we,
  input  stamp_t            wr_stamp,
  input  logic [CODE_W-1:0] rd_addr,
  output stamp_t            rd_stamp
);
  localparam int unsigned N     = 1 << CODE_W;
  localparam int unsigned WORDW = SEC_W + NSEC_W;

  logic [WORDW-1:0] mem_q [N];
  logic [N-1:0]     ok_q;
  logic [N-1:0]     hit_v;

  for (genvar i = 0; i < N; i++) begin : g_ent
    if (i == 0) begin : g_tick
      assign hit_v[i] = tick_we;
    end else begin : g_evt
      assign hit_v[i] = evt_we && (evt_addr == CODE_W'(i));
    end

    always_ff @(posedge clk) begin
      if (hit_v[i]) mem_q[i] <= {wr_stamp.nsec, wr_stamp.sec};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ok_q[i] <= 1'b0;
      else if (hit_v[i]) ok_q[i] <= wr_stamp.ok;
    end
  end

  always_comb begin
    if (hit_v[rd_addr]) rd_stamp = wr_stamp;
    else                rd_stamp = stamp_t'({ok_q[rd_addr], mem_q[rd_addr]});
  end

  assert_ok_stable_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_we && !tick_we) |=> $stable(ok_q));
  assert_tick_entry0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_we |=> ok_q[0] == $past(wr_stamp.ok));
endmodule

// File: rtl/evt_read_fmt.sv
module evt_read_fmt
  import evt_stamp_pkg::*;
#(
  parameter int unsigned PID_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  stamp_t            entry,
  input  logic [SEC_W-1:0]  sys_sec,
  input  logic [NSEC_W-1:0] sys_nsec,
  output logic              rd_valid,
  output logic [SEC_W-1:0]  rd_sec,
  output logic [NSEC_W-1:0] rd_nsec,
  output logic [31:0]       rd_status
);
  localparam logic [NSEC_W-1:0] PID_BAD = NSEC_W'((64'd1 << PID_W) - 64'd1);

  logic              valid_d;
  logic [SEC_W-1:0]  sec_d;
  logic [NSEC_W-1:0] nsec_d;
  logic [31:0]       status_d;

  always_comb begin
    valid_d = rd_en;
    if (entry.ok) begin
      sec_d    = entry.sec;
      nsec_d   = entry.nsec;
      status_d = 32'h0;
    end else begin
      sec_d    = sys_sec;
      nsec_d   = sys_nsec | PID_BAD;
      status_d = 32'hFFFF_FFFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_sec    <= '0;
      rd_nsec   <= '0;
      rd_status <= '0;
    end else begin
      rd_valid <= valid_d;
      if (rd_en) begin
        rd_sec    <= sec_d;
        rd_nsec   <= nsec_d;
        rd_status <= status_d;
      end
    end
  end
endmodule

// File: rtl/evt_stamp_table.sv
module evt_stamp_table
  import evt_stamp_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned PID_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cur_sec,
  input  logic [31:0]       cur_nsec,
  input  logic              cur_ok,
  input  logic [31:0]       sys_sec,
  input  logic [31:0]       sys_nsec,
  input  logic              evt_vld,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              tick120,
  input  logic              en_we,
  input  logic [CODE_W-1:0] en_addr,
  input  logic              en_data,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_code,
  output logic              rd_valid,
  output logic [31:0]       rd_sec,
  output logic [31:0]       rd_nsec,
  output logic [31:0]       rd_status
);
  localparam int unsigned N = 1 << CODE_W;

  logic [N-1:0] en_q;
  logic         evt_we;
  stamp_t       cur_stamp;
  stamp_t       rd_entry;

  always_comb begin
    cur_stamp = '{ok: cur_ok, nsec: cur_nsec, sec: cur_sec};
    evt_we    = evt_vld && (evt_code != '0) && en_q[evt_code];
  end

  evt_irq_enables #(.CODE_W(CODE_W)) enables_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (en_we),
    .addr (en_addr),
    .data (en_data),
    .en_q (en_q)
  );

  evt_stamp_store #(.CODE_W(CODE_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_we  (evt_we),
    .evt_addr(evt_code),
    .tick_we (tick120),
    .wr_stamp(cur_stamp),
    .rd_addr (rd_code),
    .rd_stamp(rd_entry)
  );

  evt_read_fmt #(.PID_W(PID_W)) fmt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .entry    (rd_entry),
    .sys_sec  (sys_sec),
    .sys_nsec (sys_nsec),
    .rd_valid (rd_valid),
    .rd_sec   (rd_sec),
    .rd_nsec  (rd_nsec),
    .rd_status(rd_status)
  );

  assert_rd_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_sec) && $stable(rd_nsec)));
  assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_status == 32'h0 || rd_status == 32'hFFFF_FFFF));
  assert_fallback_pid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_status != 32'h0) |-> (&rd_nsec[PID_W-1:0]));
  assert_fallback_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_status != 32'h0) |-> rd_sec == $past(sys_sec));
endmodule

// File: tb/evt_stamp_table_tb_top.sv
module evt_stamp_table_tb_top;
  typedef struct packed {
    logic [7:0]  code;
    logic        en;
    logic        ok;
    logic [31:0] sec;
    logic [31:0] nsec;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{code: 8'd3,   en: 1'b1, ok: 1'b1, sec: 32'h0000_0100, nsec: 32'h0000_0A01},
    '{code: 8'd4,   en: 1'b0, ok: 1'b1, sec: 32'h0000_0200, nsec: 32'h0001_0002},
    '{code: 8'd7,   en: 1'b1, ok: 1'b0, sec: 32'h0000_0300, nsec: 32'h0ABC_0003},
    '{code: 8'd3,   en: 1'b1, ok: 1'b1, sec: 32'h0000_0400, nsec: 32'h1234_0004},
    '{code: 8'd255, en: 1'b1, ok: 1'b1, sec: 32'hFFFF_FFF0, nsec: 32'h3B9A_C9FF},
    '{code: 8'd3,   en: 1'b0, ok: 1'b1, sec: 32'h0000_0600, nsec: 32'h0000_0006},
    '{code: 8'd1,   en: 1'b1, ok: 1'b1, sec: 32'h0000_0700, nsec: 32'h0000_0007}
  };

  logic        clk, rst_n;
  logic [31:0] cur_sec, cur_nsec, sys_sec, sys_nsec;
  logic        cur_ok, evt_vld, tick120, en_we, en_data, rd_en;
  logic [7:0]  evt_code, en_addr, rd_code;
  logic        rd_valid;
  logic [31:0] rd_sec, rd_nsec, rd_status;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit          m_en  [256];
  bit          m_ok  [256];
  logic [31:0] m_sec [256];
  logic [31:0] m_nsec[256];

  evt_stamp_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .cur_sec(cur_sec), .cur_nsec(cur_nsec), .cur_ok(cur_ok),
    .sys_sec(sys_sec), .sys_nsec(sys_nsec),
    .evt_vld(evt_vld), .evt_code(evt_code), .tick120(tick120),
    .en_we(en_we), .en_addr(en_addr), .en_data(en_data),
    .rd_en(rd_en), .rd_code(rd_code),
    .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_nsec(rd_nsec), .rd_status(rd_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [96:0] act, logic [96:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [96:0] expect_of(logic [7:0] c);
    if (m_ok[c]) return {1'b1, m_sec[c], m_nsec[c], 32'h0};
    return {1'b1, sys_sec, sys_nsec | 32'h0001_FFFF, 32'hFFFF_FFFF};
  endfunction

  task automatic set_en(logic [7:0] c, logic v);
    en_we = 1'b1; en_addr = c; en_data = v;
    cycle();
    en_we = 1'b0;
    m_en[c] = v;
  endtask

  task automatic model_evt(logic [7:0] c, logic [31:0] s, logic [31:0] ns, logic ok);
    if (c != 8'd0 && m_en[c]) begin
      m_ok[c] = ok; m_sec[c] = s; m_nsec[c] = ns;
    end
  endtask

  task automatic fire(logic [7:0] c, logic [31:0] s, logic [31:0] ns, logic ok);
    evt_vld = 1'b1; evt_code = c; cur_sec = s; cur_nsec = ns; cur_ok = ok;
    cycle();
    evt_vld = 1'b0;
    model_evt(c, s, ns, ok);
  endtask

  task automatic read_chk(logic [7:0] c, string tag);
    logic [96:0] exp;
    rd_en = 1'b1; rd_code = c;
    exp = expect_of(c);
    cycle();
    rd_en = 1'b0;
    check(tag, {rd_valid, rd_sec, rd_nsec, rd_status}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_en[i] = 0; m_ok[i] = 0; m_sec[i] = '0; m_nsec[i] = '0;
    end
    rst_n = 1'b0;
    cur_sec = '0; cur_nsec = '0; cur_ok = 1'b0;
    sys_sec = 32'h5000_0000; sys_nsec = 32'h1234_5678;
    evt_vld = 1'b0; evt_code = '0; tick120 = 1'b0;
    en_we = 1'b0; en_addr = '0; en_data = 1'b0;
    rd_en = 1'b0; rd_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycle();

    // R1 / R6: idle after reset, never-written entries fall back
    check("R1 rd_valid after reset", {96'h0, rd_valid}, 97'h0);
    read_chk(8'd5, "R1 reset entry 5 fallback");
    read_chk(8'd0, "R1 reset entry 0 fallback");

    // R2 R3 R7 R8: table-driven event/read pairs
    for (int v = 0; v < NV; v++) begin
      set_en(VECS[v].code, VECS[v].en);
      fire(VECS[v].code, VECS[v].sec, VECS[v].nsec, VECS[v].ok);
      read_chk(VECS[v].code, $sformatf("R2 R3 R7 R8 vector %0d", v));
    end

    // R6: data held and rd_valid low when no request follows
    cycle();
    check("R6 hold without request", {rd_valid, rd_sec, rd_nsec, rd_status},
          {1'b0, m_sec[1], m_nsec[1], 32'h0});

    // R8: fallback follows sys time sampled in request cycle
    sys_sec = 32'h6000_0001; sys_nsec = 32'h0000_0000;
    read_chk(8'd4, "R8 new sys time fallback");

    // R4: code 0 event with enable set does not write
    set_en(8'd0, 1'b1);
    fire(8'd0, 32'h0000_0900, 32'h0000_0009, 1'b1);
    read_chk(8'd0, "R4 code 0 event ignored");

    // R4: tick writes entry 0 even with enable cleared
    set_en(8'd0, 1'b0);
    tick120 = 1'b1; cur_sec = 32'h0000_0A00; cur_nsec = 32'h0000_000A; cur_ok = 1'b1;
    cycle();
    tick120 = 1'b0;
    m_ok[0] = 1; m_sec[0] = 32'h0000_0A00; m_nsec[0] = 32'h0000_000A;
    read_chk(8'd0, "R4 tick writes entry 0");

    // R5: enable written in same cycle as event is not yet seen
    en_we = 1'b1; en_addr = 8'd9; en_data = 1'b1;
    evt_vld = 1'b1; evt_code = 8'd9; cur_sec = 32'h0000_0B00; cur_nsec = 32'h0000_000B; cur_ok = 1'b1;
    cycle();
    en_we = 1'b0; evt_vld = 1'b0;
    m_en[9] = 1;
    read_chk(8'd9, "R5 same-cycle enable not seen");
    fire(8'd9, 32'h0000_0C00, 32'h0000_000C, 1'b1);
    read_chk(8'd9, "R5 enable seen next cycle");

    // R9: read same code as event write returns new value
    set_en(8'd12, 1'b1);
    evt_vld = 1'b1; evt_code = 8'd12; cur_sec = 32'h0000_0D00; cur_nsec = 32'h0000_000D; cur_ok = 1'b1;
    rd_en = 1'b1; rd_code = 8'd12;
    model_evt(8'd12, 32'h0000_0D00, 32'h0000_000D, 1'b1);
    begin
      logic [96:0] exp;
      exp = expect_of(8'd12);
      cycle();
      evt_vld = 1'b0; rd_en = 1'b0;
      check("R9 event bypass", {rd_valid, rd_sec, rd_nsec, rd_status}, exp);
    end

    // R9: tick bypass on entry 0, with invalid status -> fallback
    tick120 = 1'b1; cur_sec = 32'h0000_0E00; cur_nsec = 32'h0000_000E; cur_ok = 1'b0;
    rd_en = 1'b1; rd_code = 8'd0;
    m_ok[0] = 0;
    begin
      logic [96:0] exp;
      exp = expect_of(8'd0);
      cycle();
      tick120 = 1'b0; rd_en = 1'b0;
      check("R9 tick bypass invalid", {rd_valid, rd_sec, rd_nsec, rd_status}, exp);
    end

    // R10: tick and non-zero event in the same cycle
    set_en(8'd20, 1'b1);
    tick120 = 1'b1; evt_vld = 1'b1; evt_code = 8'd20;
    cur_sec = 32'h0000_0F00; cur_nsec = 32'h0000_000F; cur_ok = 1'b1;
    cycle();
    tick120 = 1'b0; evt_vld = 1'b0;
    m_ok[0] = 1; m_sec[0] = 32'h0000_0F00; m_nsec[0] = 32'h0000_000F;
    model_evt(8'd20, 32'h0000_0F00, 32'h0000_000F, 1'b1);
    read_chk(8'd0,  "R10 entry 0 from tick");
    read_chk(8'd20, "R10 entry 20 from event");

    // R8: valid entry overwritten with invalid status falls back
    fire(8'd20, 32'h0000_1000, 32'h0000_0010, 1'b0);
    read_chk(8'd20, "R8 stored invalid falls back");

    // R3: entry 255 untouched by disabled event
    set_en(8'd255, 1'b0);
    fire(8'd255, 32'h0000_1100, 32'h0000_0011, 1'b1);
    read_chk(8'd255, "R3 disabled 255 unchanged");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule